// File: doc/BRIEF.md
# First-Come-First-Served Request Arbiter

This block shares one bus channel among a parameterised set of clients (2 to 16) and grants it in arrival order. Every clock it samples the request vector and picks the requester that has been waiting longest without a grant. The grant is one-hot and registered. A valid flag and the binary index of the winner come with it. A client that was just granted and still requests goes to the back of the line. Clients that begin requesting in the same cycle are queued lowest index first.

Internally the block keeps a complete pairwise age relation over all clients. Any client that is idle, has withdrawn or has just been served moves to the young end of that relation. This gives three results:
- Continuous requesters keep their seniority.
- A returning client joins as the newest arrival.
- The age order is rebuilt every cycle with no counters.

The reset input is asynchronous and active low. Its release is assumed to be synchronised upstream.

Top module: `fcfs_arb`

## Requirements
- R1: While reset is low, and in the first cycle after it, the grant vector, the valid flag and the index are all zero. Reset clears the age ordering.
- R2: The grant is registered. Outputs after rising edge k reflect the request vector sampled at edge k. The grant vector has at most one bit set, and the valid flag is high exactly when the sampled request vector was nonzero.
- R3: When valid is high, the index is the bit position of the single set grant bit (client c is bit c of every vector). When valid is low, the index and the grant are zero.
- R4: Among the sampled requesters, the grant goes to the one whose current request run started earliest. A run ends on a grant or a deassertion.
- R5: Clients whose request runs start on the same sampled cycle are ordered lowest index first.
- R6: The client granted on a cycle, if it requests again on the next sampled cycle, is ordered behind every other requester of that cycle. This includes clients whose requests start on that same cycle.
- R7: A client that deasserts its request before being granted loses its place. When it requests again it counts as a new arrival.
- R8: A client that keeps its request high is granted within N_CLIENTS sampled cycles.
- R9: A grant bit is set only for a client whose request was high in the sampled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CLIENTS | Request vector, bit c for client c |
| gnt_o | output | N_CLIENTS | Registered one-hot grant |
| gnt_vld_o | output | 1 | A grant is present this cycle |
| gnt_idx_o | output | IDX_W | Binary index of the granted client |

## Verification
The hardest case to reach from the ports is a three-way ordering conflict in a single cycle:
- a client that was just served and keeps requesting;
- a lower-index client that starts requesting on that same cycle;
- a waiting client that withdraws while others arrive.

Directed sequences build each of these conflicts on purpose. A long phase of sticky random requests then follows, in which each bit flips rarely. This produces long waits, withdrawals in the middle of a wait, and re-arrivals. A queue-based model in the bench predicts the winner for every cycle.

// File: rtl/fcfs_arb_pkg.sv
package fcfs_arb_pkg;

  // Width of a binary client index for n clients (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fcfs_age_order.sv
// Pairwise age relation. older_o[i][j] set means client i is ahead of j.
// Clients that are idle or were just granted move to the young end:
// idle ones by index, the granted one last.
module fcfs_age_order #(
  parameter int unsigned N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0]        win_i,
  output logic [N-1:0][N-1:0] older_o
);

  logic [N-1:0][N-1:0] older_q;
  logic [N-1:0][N-1:0] older_d;
  logic [N-1:0]        move;

  assign move = ~req_i | win_i;

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      localparam bit LowIdx = (gi < gj);
      if (gi == gj) begin : g_diag
        assign older_d[gi][gj] = 1'b0;
      end else begin : g_pair
        always_comb begin
          if (!move[gi] && !move[gj]) begin
            older_d[gi][gj] = older_q[gi][gj];
          end else if (!move[gi]) begin
            older_d[gi][gj] = 1'b1;
          end else if (!move[gj]) begin
            older_d[gi][gj] = 1'b0;
          end else begin
            older_d[gi][gj] = win_i[gj] | (!win_i[gi] & LowIdx);
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else begin
      older_q <= older_d;
    end
  end

  assign older_o = older_q;

endmodule

// File: rtl/fcfs_winner.sv
// Combinational pick: the requester that is ahead of every other requester.
module fcfs_winner #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic [N-1:0]        win_o,
  output logic [IDX_W-1:0]    idx_o
);

  for (genvar gi = 0; gi < N; gi++) begin : g_cand
    logic [N-1:0] beats;
    for (genvar gj = 0; gj < N; gj++) begin : g_vs
      assign beats[gj] = ~req_i[gj] | older_i[gi][gj] | (gi == gj);
    end
    assign win_o[gi] = req_i[gi] & (&beats);
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (win_o[k]) begin
        idx_o = idx_o | IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/fcfs_arb.sv
module fcfs_arb #(
  parameter int unsigned N_CLIENTS = 4
) (
  input  logic                                            clk_i,
  input  logic                                            rst_ni,
  input  logic [N_CLIENTS-1:0]                            req_i,
  output logic [N_CLIENTS-1:0]                            gnt_o,
  output logic                                            gnt_vld_o,
  output logic [fcfs_arb_pkg::idx_w(N_CLIENTS)-1:0]       gnt_idx_o
);

  localparam int unsigned IDX_W = fcfs_arb_pkg::idx_w(N_CLIENTS);

  logic [N_CLIENTS-1:0][N_CLIENTS-1:0] older;
  logic [N_CLIENTS-1:0]                win;
  logic [IDX_W-1:0]                    win_idx;

  logic [N_CLIENTS-1:0] gnt_q;
  logic                 vld_q;
  logic [IDX_W-1:0]     idx_q;

  fcfs_age_order #(.N(N_CLIENTS)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .win_i   (win),
    .older_o (older)
  );

  fcfs_winner #(.N(N_CLIENTS), .IDX_W(IDX_W)) u_pick (
    .req_i   (req_i),
    .older_i (older),
    .win_o   (win),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      gnt_q <= win;
      vld_q <= |req_i;
      idx_q <= win_idx;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;
  assign gnt_idx_o = idx_q;

endmodule

// File: rtl/fcfs_arb_chk.sv
module fcfs_arb_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     req_i,
  input logic [N-1:0]     gnt_o,
  input logic             gnt_vld_o,
  input logic [IDX_W-1:0] gnt_idx_o
);

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_vld_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (gnt_vld_o == (|$past(req_i))));

  assert_idx_matches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> (gnt_o == ({{(N-1){1'b0}}, 1'b1} << gnt_idx_o)));

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_vld_o |-> (gnt_o == '0 && gnt_idx_o == '0));

  assert_gnt_had_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (|gnt_o)) |-> (|($past(req_i) & gnt_o)));

  for (genvar gc = 0; gc < N; gc++) begin : g_wait
    logic [5:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q <= '0;
      end else if (req_i[gc] && !gnt_o[gc]) begin
        wait_q <= (wait_q == 6'd63) ? wait_q : wait_q + 6'd1;
      end else begin
        wait_q <= '0;
      end
    end
    assert_no_starve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q <= 6'(N));
  end

endmodule

bind fcfs_arb fcfs_arb_chk #(.N(N_CLIENTS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o),
  .gnt_idx_o (gnt_idx_o)
);

// File: tb/sim_fcfs_arb.sv
`timescale 1ns/1ps
module sim_fcfs_arb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic         vld;
  logic [1:0]   idx;

  int n_vec = 0;
  int n_bad = 0;
  int q[$];
  int last_w = -1;
  int exp_w = -1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fcfs_arb #(.N_CLIENTS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .gnt_o(gnt), .gnt_vld_o(vld), .gnt_idx_o(idx)
  );

  function automatic bit in_q(input int c);
    foreach (q[k]) if (q[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  // Behavioural line of waiting clients, oldest at the front.
  task automatic model_step(input logic [N-1:0] r);
    int keep[$];
    foreach (q[k]) if (r[q[k]]) keep.push_back(q[k]);
    q = keep;
    for (int c = 0; c < N; c++)
      if (r[c] && c != last_w && !in_q(c)) q.push_back(c);
    if (last_w >= 0 && r[last_w]) q.push_back(last_w);
    if (q.size() > 0) exp_w = q.pop_front();
    else              exp_w = -1;
    last_w = exp_w;
  endtask

  task automatic check(input string tag);
    logic [N-1:0] eg;
    logic         ev;
    logic [1:0]   ei;
    eg = (exp_w < 0) ? '0 : (N'(1) << exp_w);
    ev = (exp_w >= 0);
    ei = (exp_w < 0) ? 2'd0 : 2'(exp_w);
    n_vec++;
    if (gnt !== eg || vld !== ev || idx !== ei) begin
      n_bad++;
      $display("FAIL %s: gnt=%b vld=%b idx=%0d expected gnt=%b vld=%b idx=%0d",
               tag, gnt, vld, idx, eg, ev, ei);
    end
  endtask

  // Drive r (at a falling edge), let the edge sample it, check at next fall.
  task automatic cycle(input logic [N-1:0] r, input string tag);
    req = r;
    @(posedge clk);
    model_step(r);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    q.delete();
    last_w = -1;
    exp_w = -1;
    repeat (2) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired (R8 progress)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rv;
    @(negedge clk);
    do_reset();
    // R1: first cycle after reset with no request
    cycle(4'b0000, "R1 after reset");
    // R2: idle valid low, lone requester granted every cycle
    cycle(4'b0000, "R2 idle");
    cycle(4'b0010, "R2 single");
    cycle(4'b0010, "R2 single");
    cycle(4'b0010, "R3 single idx");
    cycle(4'b0000, "R2 drop");
    // R5: simultaneous arrival, index order
    cycle(4'b1111, "R5 tie");
    cycle(4'b1111, "R5 tie");
    cycle(4'b1111, "R5 tie");
    cycle(4'b1111, "R5 tie");
    cycle(4'b0000, "R2 idle");
    // R4: staggered arrivals served by age
    cycle(4'b0001, "R4 age");
    cycle(4'b1001, "R4 age");
    cycle(4'b1011, "R4 age");
    cycle(4'b1111, "R4 age");
    cycle(4'b1111, "R4 age");
    cycle(4'b1111, "R4 age");
    cycle(4'b0000, "R2 idle");
    // R6: just-granted client goes behind a lower-index newcomer
    cycle(4'b0100, "R6 served last");
    cycle(4'b0101, "R6 served last");
    cycle(4'b0101, "R6 served last");
    cycle(4'b0101, "R6 served last");
    cycle(4'b0000, "R2 idle");
    // R7: withdrawal loses place
    cycle(4'b0111, "R7 withdraw");
    cycle(4'b0101, "R7 withdraw");
    cycle(4'b0111, "R7 rejoin");
    cycle(4'b0111, "R7 rejoin");
    cycle(4'b0111, "R7 rejoin");
    // R1: reset in mid-traffic clears ordering
    req = 4'b1110;
    do_reset();
    cycle(4'b1110, "R1 order cleared");
    cycle(4'b1111, "R1 order cleared");
    cycle(4'b1111, "R1 order cleared");
    // R8 R9: sticky random traffic
    rv = 4'b0000;
    for (int t = 0; t < 4000; t++) begin
      for (int b = 0; b < N; b++)
        if ($urandom_range(7) == 0) rv[b] = ~rv[b];
      cycle(rv, "R8 R9 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule